// File: doc/BRIEF.md
# Buffered-Write Flash Command Sequencer

This controller runs block erase and buffered program operations on a flash that exposes a status-register command set. The host sets up a request and pulses `start`. For an erase it gives a block base. For a program it gives a block base, a start word address and a word count. Program data is loaded beforehand into a small internal word buffer. The sequencer then writes the command bytes on a synchronous flash bus and polls status until the device reports ready, or until a poll budget that the host sets runs out.

Two chips can sit side by side on a 32-bit bus, each owning one 16-bit lane. In that case every command value is repeated in both lanes, and ready is accepted only when every lane shows it. A program is cut into chunks. The first chunk is shortened so that every later chunk starts on a write-buffer boundary. Each operation ends by clearing status and returning the device to read-array mode. The host then sees a one-cycle `done`, an error code decoded from the last status word, and a timeout flag.

The flash bus is synchronous. `fl_we` writes `fl_wdata` to `fl_addr` at the clock edge. `fl_re` requests a read, and the flash returns the data on `fl_rdata` in the following cycle.

Top module: `bufwr_flash_seq`

## Requirements
- R1: An erase writes 0x20 and then 0xD0 to the block base. It then reads status at the block base until bit 7 is set. The bus never carries a write and a read in the same cycle.
- R2: A program chunk begins by writing 0xE8 to the block base and then reading back at the block base. While bit 7 of the read value is clear, the 0xE8 write and the read are repeated.
- R3: Once the buffer is granted, the sequencer writes (chunk length − 1) to the block base. It then writes the chunk's data words to consecutive addresses starting at the chunk's address, taking them from the buffer in order. Next it writes 0xD0 to the block base. It then reads status at the block base until ready. Every read the sequencer issues targets the block base.
- R4: The chunk length is the smaller of the remaining word count and (WB_WORDS − (address mod WB_WORDS)). Chunks follow each other until the count is used up.
- R5: With two lanes, each command value is zero-extended to 16 bits and placed in both lanes. Ready requires bit 7 to be set in every lane.
- R6: While status is polled after a confirm, a timeout occurs when `tmo_limit`+1 consecutive reads have all been not ready. The timeout sets `timed_out` and the sequence goes straight to the ending writes.
- R7: While the buffer is being requested, a timeout occurs when `tmo_limit`+1 consecutive reads have all been not ready. The sequencer then writes 0x70 to the block base, reads once, and captures that word on `status`. After that it performs the ending writes, and `timed_out` is set.
- R8: Every operation ends by writing 0x50 and then 0xFF to the block base. `done` is then high for exactly one cycle, with `busy` low in that cycle.
- R9: `err_code` is decoded from the captured status word, with all lanes ORed together. The codes are: 1 for lock (bit 1), 2 for low voltage (bit 3), 3 for program failure (bit 4) and 4 for erase failure (bit 5). When several bits are set, the earlier code in that list wins. The code is 0 when none of these bits is set. A chunk whose final status shows an error bit stops the program, and no further chunks are issued.
- R10: A `start` that arrives while `busy` is high is ignored. A program request with a count of zero is ignored and does not make the block busy.
- R11: After reset, `busy`, `done`, `timed_out`, `fl_we`, `fl_re` and `err_code` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| op_prog | input | 1 | 1 = buffered program, 0 = block erase |
| blk_addr | input | ADDR_W | Block base word address |
| wr_addr | input | ADDR_W | First word address of a program |
| wr_count | input | CNT_W | Number of words to program |
| tmo_limit | input | TMO_W | Poll budget; a timeout follows tmo_limit+1 unready reads |
| buf_we | input | 1 | Write enable of the data buffer |
| buf_idx | input | IDX_W | Buffer slot being written |
| buf_wdata | input | BUS_W | Data word for the buffer |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| timed_out | output | 1 | The last operation ended on a timeout |
| err_code | output | 3 | Decoded error of the last operation |
| status | output | BUS_W | Last captured status word |
| fl_we | output | 1 | Flash bus write strobe |
| fl_re | output | 1 | Flash bus read strobe |
| fl_addr | output | ADDR_W | Flash bus word address |
| fl_wdata | output | BUS_W | Flash bus write data |
| fl_rdata | input | BUS_W | Flash bus read data, valid one cycle after fl_re |

## Verification
The bench aims at the chunk split for an unaligned start. If the split were wrong, data words would land across a write-buffer boundary, or the count word would not match the number of data words that follow it. It drives a status word where only one lane is ready. A design that checked a single lane would finish early instead of timing out.

It also holds off the buffer grant. A design that gave up too soon, or that failed to issue 0x70 before aborting, would show the wrong write log and the wrong captured status. Two further cases are a status word with several error bits set, where a wrong priority yields the wrong code, and a chunk that reports a program error, where a design that kept going would issue extra chunks. A start during a busy operation and a zero-length program are both checked to leave the write log unchanged.

// File: rtl/flseq_pkg.sv
package flseq_pkg;

   localparam logic [7:0] CMD_ERASE   = 8'h20;
   localparam logic [7:0] CMD_CONFIRM = 8'hD0;
   localparam logic [7:0] CMD_BUFREQ  = 8'hE8;
   localparam logic [7:0] CMD_RDSTAT  = 8'h70;
   localparam logic [7:0] CMD_CLRSTAT = 8'h50;
   localparam logic [7:0] CMD_READARR = 8'hFF;

   localparam int BIT_READY = 7;
   localparam int BIT_LOCK  = 1;
   localparam int BIT_VOLT  = 3;
   localparam int BIT_PROG  = 4;
   localparam int BIT_ERASE = 5;

   typedef enum logic [2:0] {
      ERR_NONE  = 3'd0,
      ERR_LOCK  = 3'd1,
      ERR_VOLT  = 3'd2,
      ERR_PROG  = 3'd3,
      ERR_ERASE = 3'd4
   } err_code_t;

   typedef enum logic [4:0] {
      S_IDLE, S_E_SET, S_E_CONF, S_W_RD, S_W_CHK,
      S_P_START, S_P_REQ, S_P_RRD, S_P_CHK, S_P_CNT, S_P_DAT, S_P_CONF,
      S_P_SRQ, S_P_SRD, S_P_SCAP, S_CLR, S_RST
   } seq_state_t;

endpackage

// File: rtl/flseq_stat_decode.sv
module flseq_stat_decode
   import flseq_pkg::*;
#(
   parameter int LANES = 2
) (
   input  logic [LANES*16-1:0] word,
   output logic                ready,
   output logic                any_err,
   output logic [2:0]          code
);
   logic [LANES-1:0] rdy_l, lock_l, volt_l, prog_l, ers_l;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign rdy_l[g]  = word[g*16 + BIT_READY];
      assign lock_l[g] = word[g*16 + BIT_LOCK];
      assign volt_l[g] = word[g*16 + BIT_VOLT];
      assign prog_l[g] = word[g*16 + BIT_PROG];
      assign ers_l[g]  = word[g*16 + BIT_ERASE];
   end

   assign ready   = &rdy_l;
   assign any_err = |{lock_l, volt_l, prog_l, ers_l};

   always_comb begin
      if (|lock_l)      code = ERR_LOCK;
      else if (|volt_l) code = ERR_VOLT;
      else if (|prog_l) code = ERR_PROG;
      else if (|ers_l)  code = ERR_ERASE;
      else              code = ERR_NONE;
   end
endmodule

// File: rtl/flseq_poll_timer.sv
module flseq_poll_timer #(
   parameter int TMO_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   input  logic [TMO_W-1:0] limit,
   output logic             expired
);
   logic [TMO_W-1:0] cnt_q;

   if (TMO_W < 1) begin : g_bad_w
      $error("TMO_W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (clr) cnt_q <= '0;
      else if (inc) cnt_q <= cnt_q + 1'b1;
   end

   assign expired = (cnt_q >= limit);

   AST_INC_BEFORE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      inc |-> !expired); // R6
endmodule

// File: rtl/flseq_wbuf.sv
module flseq_wbuf #(
   parameter int DEPTH = 8,
   parameter int WIDTH = 32,
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             we,
   input  logic [IDX_W-1:0] widx,
   input  logic [WIDTH-1:0] wdata,
   input  logic [IDX_W-1:0] ridx,
   output logic [WIDTH-1:0] rdata
);
   logic [WIDTH-1:0] mem [DEPTH];

   if (DEPTH < 1) begin : g_bad_depth
      $error("DEPTH must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (we) mem[widx] <= wdata;
   end

   assign rdata = mem[ridx];
endmodule

// File: rtl/bufwr_flash_seq.sv
module bufwr_flash_seq
   import flseq_pkg::*;
#(
   parameter int LANES    = 2,
   parameter int ADDR_W   = 16,
   parameter int DEPTH    = 8,
   parameter int WB_WORDS = 4,
   parameter int TMO_W    = 16,
   localparam int BUS_W   = LANES * 16,
   localparam int CNT_W   = $clog2(DEPTH + 1),
   localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int WBL     = $clog2(WB_WORDS),
   localparam int LEN_W   = $clog2(WB_WORDS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              op_prog,
   input  logic [ADDR_W-1:0] blk_addr,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_count,
   input  logic [TMO_W-1:0]  tmo_limit,
   input  logic              buf_we,
   input  logic [IDX_W-1:0]  buf_idx,
   input  logic [BUS_W-1:0]  buf_wdata,
   output logic              busy,
   output logic              done,
   output logic              timed_out,
   output logic [2:0]        err_code,
   output logic [BUS_W-1:0]  status,
   output logic              fl_we,
   output logic              fl_re,
   output logic [ADDR_W-1:0] fl_addr,
   output logic [BUS_W-1:0]  fl_wdata,
   input  logic [BUS_W-1:0]  fl_rdata
);
   if (LANES != 1 && LANES != 2) begin : g_bad_lanes
      $error("LANES must be 1 or 2");
   end
   if (WB_WORDS < 2 || (1 << WBL) != WB_WORDS || WB_WORDS > 256) begin : g_bad_wb
      $error("WB_WORDS must be a power of two from 2 to 256");
   end
   if (ADDR_W < WBL + 1) begin : g_bad_addr
      $error("ADDR_W too small for WB_WORDS");
   end

   function automatic logic [BUS_W-1:0] mirror(input logic [15:0] v);
      return {LANES{v}};
   endfunction

   seq_state_t             state_q;
   logic [ADDR_W-1:0]      base_q, off_q;
   logic [CNT_W-1:0]       rem_q;
   logic [LEN_W-1:0]       len_q, fidx_q, room, chunk;
   logic [IDX_W-1:0]       bidx_q;
   logic                   prog_q, tmo_q, done_q;
   logic [BUS_W-1:0]       stat_q, buf_rdata;
   logic                   rd_ready, rd_err, t_clr, t_inc, t_exp;
   logic [2:0]             rd_code, st_code;

   flseq_wbuf #(.DEPTH(DEPTH), .WIDTH(BUS_W)) u_buf (
      .clk(clk), .we(buf_we), .widx(buf_idx), .wdata(buf_wdata),
      .ridx(bidx_q), .rdata(buf_rdata));

   flseq_stat_decode #(.LANES(LANES)) u_rd_dec (
      .word(fl_rdata), .ready(rd_ready), .any_err(rd_err), .code(rd_code));

   flseq_stat_decode #(.LANES(LANES)) u_st_dec (
      .word(stat_q), .ready(), .any_err(), .code(st_code));

   assign t_clr = (state_q == S_E_CONF) || (state_q == S_P_START) || (state_q == S_P_CONF);
   assign t_inc = ((state_q == S_W_CHK) || (state_q == S_P_CHK)) && !rd_ready && !t_exp;

   flseq_poll_timer #(.TMO_W(TMO_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .clr(t_clr), .inc(t_inc),
      .limit(tmo_limit), .expired(t_exp));

   // chunk length: stop at the next write-buffer boundary or at the end
   assign room  = LEN_W'(WB_WORDS) - LEN_W'(off_q[WBL-1:0]);
   assign chunk = ({{CNT_W{1'b0}}, room} > {{LEN_W{1'b0}}, rem_q}) ? LEN_W'(rem_q) : room;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         base_q  <= '0;
         off_q   <= '0;
         rem_q   <= '0;
         len_q   <= '0;
         fidx_q  <= '0;
         bidx_q  <= '0;
         prog_q  <= 1'b0;
         tmo_q   <= 1'b0;
         done_q  <= 1'b0;
         stat_q  <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            S_IDLE: if (start && (!op_prog || wr_count != '0)) begin
               base_q  <= blk_addr;
               off_q   <= wr_addr;
               rem_q   <= wr_count;
               bidx_q  <= '0;
               prog_q  <= op_prog;
               tmo_q   <= 1'b0;
               stat_q  <= '0;
               state_q <= op_prog ? S_P_START : S_E_SET;
            end
            S_E_SET:  state_q <= S_E_CONF;
            S_E_CONF: state_q <= S_W_RD;
            S_W_RD:   state_q <= S_W_CHK;
            S_W_CHK: begin
               stat_q <= fl_rdata;
               if (rd_ready) begin
                  if (!prog_q || rd_err || rem_q == CNT_W'(len_q)) begin
                     state_q <= S_CLR;
                  end else begin
                     off_q   <= off_q + ADDR_W'(len_q);
                     rem_q   <= rem_q - CNT_W'(len_q);
                     state_q <= S_P_START;
                  end
               end else if (t_exp) begin
                  tmo_q   <= 1'b1;
                  state_q <= S_CLR;
               end else begin
                  state_q <= S_W_RD;
               end
            end
            S_P_START: begin
               len_q   <= chunk;
               state_q <= S_P_REQ;
            end
            S_P_REQ: state_q <= S_P_RRD;
            S_P_RRD: state_q <= S_P_CHK;
            S_P_CHK: begin
               if (rd_ready) begin
                  state_q <= S_P_CNT;
               end else if (t_exp) begin
                  tmo_q   <= 1'b1;
                  state_q <= S_P_SRQ;
               end else begin
                  state_q <= S_P_REQ;
               end
            end
            S_P_CNT: begin
               fidx_q  <= '0;
               state_q <= S_P_DAT;
            end
            S_P_DAT: begin
               fidx_q <= fidx_q + 1'b1;
               bidx_q <= bidx_q + 1'b1;
               if (fidx_q == len_q - 1'b1) state_q <= S_P_CONF;
            end
            S_P_CONF: state_q <= S_W_RD;
            S_P_SRQ:  state_q <= S_P_SRD;
            S_P_SRD:  state_q <= S_P_SCAP;
            S_P_SCAP: begin
               stat_q  <= fl_rdata;
               state_q <= S_CLR;
            end
            S_CLR: state_q <= S_RST;
            S_RST: begin
               done_q  <= 1'b1;
               state_q <= S_IDLE;
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      fl_we    = 1'b0;
      fl_re    = 1'b0;
      fl_addr  = base_q;
      fl_wdata = '0;
      unique case (state_q)
         S_E_SET:  begin fl_we = 1'b1; fl_wdata = mirror({8'h00, CMD_ERASE});   end
         S_E_CONF,
         S_P_CONF: begin fl_we = 1'b1; fl_wdata = mirror({8'h00, CMD_CONFIRM}); end
         S_P_REQ:  begin fl_we = 1'b1; fl_wdata = mirror({8'h00, CMD_BUFREQ});  end
         S_P_SRQ:  begin fl_we = 1'b1; fl_wdata = mirror({8'h00, CMD_RDSTAT});  end
         S_CLR:    begin fl_we = 1'b1; fl_wdata = mirror({8'h00, CMD_CLRSTAT}); end
         S_RST:    begin fl_we = 1'b1; fl_wdata = mirror({8'h00, CMD_READARR}); end
         S_P_CNT:  begin fl_we = 1'b1; fl_wdata = mirror(16'(len_q - 1'b1));    end
         S_P_DAT:  begin
            fl_we    = 1'b1;
            fl_addr  = off_q + ADDR_W'(fidx_q);
            fl_wdata = buf_rdata;
         end
         S_W_RD, S_P_RRD, S_P_SRD: fl_re = 1'b1;
         default: ;
      endcase
   end

   assign busy      = (state_q != S_IDLE);
   assign done      = done_q;
   assign timed_out = tmo_q;
   assign status    = stat_q;
   assign err_code  = st_code;

   AST_NO_BUS_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
      !(fl_we && fl_re)); // R1
   AST_READ_AT_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      fl_re |-> fl_addr == base_q); // R3
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R8
   AST_BASE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(base_q)); // R10

   if (LANES == 2) begin : g_mirror_chk
      AST_CMD_MIRRORED: assert property (@(posedge clk) disable iff (!rst_n)
         (fl_we && state_q != S_P_DAT) |-> fl_wdata[31:16] == fl_wdata[15:0]); // R5
   end
endmodule

// File: tb/bufwr_flash_seq_tb_top.sv
module bufwr_flash_seq_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0, op_prog = 1'b0;
   logic [15:0] blk_addr = '0, wr_addr = '0;
   logic [3:0]  wr_count = '0;
   logic [15:0] tmo_limit = 16'd5;
   logic        buf_we = 1'b0;
   logic [2:0]  buf_idx = '0;
   logic [31:0] buf_wdata = '0;
   logic        busy, done, timed_out, fl_we, fl_re;
   logic [2:0]  err_code;
   logic [31:0] status, fl_wdata;
   logic [31:0] fl_rdata = '0;
   logic [15:0] fl_addr;

   always #10 clk = ~clk;

   bufwr_flash_seq dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .op_prog(op_prog),
      .blk_addr(blk_addr), .wr_addr(wr_addr), .wr_count(wr_count),
      .tmo_limit(tmo_limit), .buf_we(buf_we), .buf_idx(buf_idx),
      .buf_wdata(buf_wdata), .busy(busy), .done(done), .timed_out(timed_out),
      .err_code(err_code), .status(status), .fl_we(fl_we), .fl_re(fl_re),
      .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata));

   // flash model: logs writes; reads answer busy n_busy times, then ready
   int          n_busy = 0;
   logic [31:0] busy_word = '0, ready_word = 32'h0080_0080;
   logic [15:0] log_a [256];
   logic [31:0] log_d [256];
   int          wcnt = 0, rdn = 0, rdcnt = 0;

   always @(posedge clk) begin
      if (fl_we) begin
         log_a[wcnt] <= fl_addr;
         log_d[wcnt] <= fl_wdata;
         wcnt <= wcnt + 1;
         if (fl_wdata != 32'h00E8_00E8) rdcnt <= 0;
      end
      if (fl_re) begin
         rdn      <= rdn + 1;
         fl_rdata <= (rdcnt < n_busy) ? busy_word : ready_word;
         rdcnt    <= rdcnt + 1;
      end
   end

   int checks = 0, bad = 0;
   logic [15:0] exp_a [64];
   logic [31:0] exp_d [64];
   int ecnt = 0;

   function automatic logic [31:0] mir(input logic [7:0] b);
      return {8'h00, b, 8'h00, b};
   endfunction

   task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string what);
      checks++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   task automatic exp_clear();
      ecnt = 0;
   endtask

   task automatic exp_add(input logic [15:0] a, input logic [31:0] d);
      exp_a[ecnt] = a;
      exp_d[ecnt] = d;
      ecnt++;
   endtask

   task automatic check_log(input int base, input string what);
      chk(64'(wcnt - base), 64'(ecnt), {what, " write count"});
      for (int i = 0; i < ecnt; i++)
         if (base + i < wcnt)
            chk({16'h0, log_a[base+i], log_d[base+i]}, {16'h0, exp_a[i], exp_d[i]},
                $sformatf("%s write %0d", what, i));
   endtask

   task automatic load_buf(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         buf_we = 1'b1; buf_idx = 3'(k); buf_wdata = 32'hA000_0000 + k;
      end
      @(negedge clk);
      buf_we = 1'b0;
   endtask

   task automatic kick(input logic prog, input logic [15:0] blk, input logic [15:0] a,
                       input logic [3:0] n);
      @(negedge clk);
      op_prog = prog; blk_addr = blk; wr_addr = a; wr_count = n; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done(input string what);
      int n = 0;
      while (!done && n < 3000) begin
         @(negedge clk);
         n++;
      end
      chk(64'(done), 64'd1, {what, " done seen"});
   endtask

   task automatic t_reset();
      chk({59'h0, busy, done, timed_out, fl_we, fl_re}, 64'h0, "R11 reset outputs");
      chk(64'(err_code), 64'h0, "R11 reset err_code");
   endtask

   task automatic t_erase();
      int wb = wcnt, rb = rdn;
      n_busy = 2; ready_word = 32'h0080_0080; tmo_limit = 16'd5;
      kick(1'b0, 16'h0100, 16'h0, 4'd0);
      wait_done("R1 erase");
      exp_clear();
      exp_add(16'h0100, mir(8'h20)); exp_add(16'h0100, mir(8'hD0));
      exp_add(16'h0100, mir(8'h50)); exp_add(16'h0100, mir(8'hFF));
      check_log(wb, "R1 R8 erase");
      chk(64'(rdn - rb), 64'd3, "R1 erase poll reads");
      chk({61'h0, timed_out, err_code != 3'd0, busy}, 64'h0, "R1 erase clean end");
      @(negedge clk);
      chk({62'h0, done, busy}, 64'h0, "R8 done one cycle");
   endtask

   task automatic t_one_lane();
      int wb = wcnt, rb = rdn;
      n_busy = 0; ready_word = 32'h0000_0080; tmo_limit = 16'd3;
      kick(1'b0, 16'h0200, 16'h0, 4'd0);
      wait_done("R5 one lane");
      chk(64'(rdn - rb), 64'd4, "R5 R6 polls until timeout");
      chk(64'(timed_out), 64'd1, "R6 timeout flag");
      exp_clear();
      exp_add(16'h0200, mir(8'h20)); exp_add(16'h0200, mir(8'hD0));
      exp_add(16'h0200, mir(8'h50)); exp_add(16'h0200, mir(8'hFF));
      check_log(wb, "R6 timeout ending");
   endtask

   task automatic exp_prog5(input logic stop_after_first);
      exp_clear();
      exp_add(16'h0100, mir(8'hE8)); exp_add(16'h0100, mir(8'h01));
      exp_add(16'h0102, 32'hA000_0000); exp_add(16'h0103, 32'hA000_0001);
      exp_add(16'h0100, mir(8'hD0));
      if (!stop_after_first) begin
         exp_add(16'h0100, mir(8'hE8)); exp_add(16'h0100, mir(8'h02));
         exp_add(16'h0104, 32'hA000_0002); exp_add(16'h0105, 32'hA000_0003);
         exp_add(16'h0106, 32'hA000_0004); exp_add(16'h0100, mir(8'hD0));
      end
      exp_add(16'h0100, mir(8'h50)); exp_add(16'h0100, mir(8'hFF));
   endtask

   task automatic t_program_split();
      int wb = wcnt, rb = rdn;
      n_busy = 0; ready_word = 32'h0080_0080; tmo_limit = 16'd5;
      load_buf(5);
      kick(1'b1, 16'h0100, 16'h0102, 4'd5);
      wait_done("R3 program");
      exp_prog5(1'b0);
      check_log(wb, "R3 R4 R5 split program");
      chk(64'(rdn - rb), 64'd4, "R3 program reads");
      chk({61'h0, timed_out, err_code}, 64'h0, "R3 program clean");
   endtask

   task automatic t_retry();
      int wb = wcnt, rb = rdn;
      n_busy = 2; ready_word = 32'h0080_0080; busy_word = 32'h0; tmo_limit = 16'd5;
      kick(1'b1, 16'h0100, 16'h0100, 4'd1);
      wait_done("R2 retry");
      exp_clear();
      exp_add(16'h0100, mir(8'hE8)); exp_add(16'h0100, mir(8'hE8));
      exp_add(16'h0100, mir(8'hE8)); exp_add(16'h0100, mir(8'h00));
      exp_add(16'h0100, 32'hA000_0000); exp_add(16'h0100, mir(8'hD0));
      exp_add(16'h0100, mir(8'h50)); exp_add(16'h0100, mir(8'hFF));
      check_log(wb, "R2 request retry");
      chk(64'(rdn - rb), 64'd6, "R2 reads");
      chk(64'(timed_out), 64'd0, "R2 no timeout");
   endtask

   task automatic t_req_timeout();
      int wb = wcnt, rb = rdn;
      n_busy = 1000; busy_word = 32'h0002_0000; tmo_limit = 16'd2;
      kick(1'b1, 16'h0100, 16'h0100, 4'd2);
      wait_done("R7 request timeout");
      exp_clear();
      exp_add(16'h0100, mir(8'hE8)); exp_add(16'h0100, mir(8'hE8));
      exp_add(16'h0100, mir(8'hE8)); exp_add(16'h0100, mir(8'h70));
      exp_add(16'h0100, mir(8'h50)); exp_add(16'h0100, mir(8'hFF));
      check_log(wb, "R7 status request");
      chk(64'(rdn - rb), 64'd4, "R7 reads");
      chk(64'(status), 64'h0002_0000, "R7 captured status");
      chk(64'(timed_out), 64'd1, "R7 timeout flag");
      chk(64'(err_code), 64'd1, "R9 lock code from lane1");
      n_busy = 0; busy_word = 32'h0;
   endtask

   task automatic t_priority(input logic [31:0] rw, input logic [2:0] code, input string what);
      n_busy = 0; ready_word = rw; tmo_limit = 16'd5;
      kick(1'b0, 16'h0300, 16'h0, 4'd0);
      wait_done(what);
      chk(64'(err_code), 64'(code), what);
   endtask

   task automatic t_prog_error();
      int wb = wcnt;
      n_busy = 0; ready_word = 32'h0090_0090; tmo_limit = 16'd5;
      kick(1'b1, 16'h0100, 16'h0102, 4'd5);
      wait_done("R9 program error");
      exp_prog5(1'b1);
      check_log(wb, "R9 stop after failing chunk");
      chk(64'(err_code), 64'd3, "R9 program error code");
      ready_word = 32'h0080_0080;
   endtask

   task automatic t_ignore();
      int wb = wcnt;
      n_busy = 0; ready_word = 32'h0080_0080; tmo_limit = 16'd5;
      kick(1'b1, 16'h0100, 16'h0102, 4'd5);
      @(negedge clk);
      @(negedge clk);
      op_prog = 1'b0; blk_addr = 16'h0300; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done("R10 start while busy");
      exp_prog5(1'b0);
      check_log(wb, "R10 busy start ignored");
      wb = wcnt;
      kick(1'b1, 16'h0100, 16'h0100, 4'd0);
      chk(64'(busy), 64'd0, "R10 zero count stays idle");
      repeat (4) @(negedge clk);
      chk(64'(wcnt - wb), 64'd0, "R10 zero count no writes");
      chk(64'(done), 64'd0, "R10 zero count no done");
   endtask

   initial begin
      #(20 * 150000);
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_erase();
      t_one_lane();
      t_program_split();
      t_retry();
      t_req_timeout();
      t_priority(32'h00A8_0080, 3'd2, "R9 voltage over erase");
      t_priority(32'h00B0_00B0, 3'd3, "R9 program over erase");
      t_priority(32'h00A0_00A0, 3'd4, "R9 erase only");
      t_priority(32'h008A_0080, 3'd1, "R9 lock over voltage");
      t_prog_error();
      t_ignore();
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end
endmodule